// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware activity for profiling. It holds one 32-bit cycle counter and six 32-bit event counters. Each event counter is tied to one 8-bit event code. The code selects a line from a 256-wide vector of core event pulses, or it picks one of a few special sources:

- a software increment,
- a constant cycle event,
- two external event inputs, taken alone or combined.

Software reaches all state through a single-cycle register port. A write is taken on any rising edge where `reg_wr` is high. Reads are combinational from `reg_addr`. There is no back-pressure on this port.

Counters are turned on in two stages: a global run bit and a per-counter enable mask. The enable mask and the interrupt mask are each changed through their own pair of set and clear addresses. An event counter is reached indirectly: software first writes the counter's index to a select register, then reads or writes the type and value registers. When a counter wraps, a sticky flag is set. The `irq` output reports every flag whose interrupt is enabled.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every counter, the control fields, both masks, the select register and all overflow flags are zero, and `irq` is low.
- R2: A counter advances on a clock edge only when control bit 0 (global run) and its own enable bit are both 1 at that edge and its event is present. Enable bit positions are 0..5 for event counters and 31 for the cycle counter.
- R3: Writing to address 1 (enable set) sets each mask bit written as 1. Writing to address 2 (enable clear) clears each mask bit written as 1. Bits written as 0 are unchanged. Reading either address returns the mask, and unimplemented bits read 0.
- R4: Writing control (address 0) with bit 1 set zeroes all event counters. Writing it with bit 2 set zeroes the cycle counter and its prescaler. Neither bit is stored: control reads back only bit 0 (run) and bit 3 (divide).
- R5: With control bit 3 set, the cycle counter advances once per 64 enabled clock edges. With bit 3 clear, it advances on every enabled edge.
- R6: Address 7 holds the counter index. Address 8 (event type, low 8 bits) and address 9 (counter value) act on the selected counter. An index above 5 reads as 0 through both addresses and makes writes to them have no effect.
- R7: Event code 0x00 counts writes to address 6 that have a 1 at the counter's bit position. Code 0x11 counts every cycle. Code 0x90 counts external input 0. Code 0x91 counts external input 1. Code 0x92 counts when either external input is high. Any other code N counts `core_evt[N]`.
- R8: When a counting counter goes from 0xFFFFFFFF to 0, its overflow flag is set: event counter i uses bit i, the cycle counter uses bit 31. The flags read at address 5 and are cleared by writing 1s there.
- R9: Writing address 3 sets interrupt enable bits and writing address 4 clears them, with the same rules as the enable mask. `irq` is high exactly when some overflow flag and its interrupt enable are both set.
- R10: A value write to a counter (address 9, or address 10 for the cycle counter) replaces any increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| core_evt | input | 256 | Event pulses, indexed by event code |
| ext_evt | input | 2 | External event inputs |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench loads counters near all-ones so that a wrap happens within two edges. A design that compared against the wrong width, or that set the flag on the wrong edge, would leave the flag or `irq` low. It writes a counter value on an edge where that counter is also counting. If the increment won, the value would read back one higher. It runs the prescaled cycle counter for exactly 128 edges and expects 2. An off-by-one in the divider would give 1 or 3. It also checks that masking the interrupt drops `irq` while the flag stays set. Finally, it checks that an out-of-range select neither reads nor writes a real counter. A decoder that truncated the index would alias counter 6 onto an existing one.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_ENSET  = 4'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_IRQSET = 4'd3;
  localparam logic [ADDR_W-1:0] A_IRQCLR = 4'd4;
  localparam logic [ADDR_W-1:0] A_OVF    = 4'd5;
  localparam logic [ADDR_W-1:0] A_SWINC  = 4'd6;
  localparam logic [ADDR_W-1:0] A_SEL    = 4'd7;
  localparam logic [ADDR_W-1:0] A_EVTYPE = 4'd8;
  localparam logic [ADDR_W-1:0] A_EVVAL  = 4'd9;
  localparam logic [ADDR_W-1:0] A_CYCVAL = 4'd10;

  localparam int CTRL_RUN   = 0;
  localparam int CTRL_EVRST = 1;
  localparam int CTRL_CYRST = 2;
  localparam int CTRL_DIV   = 3;

  localparam logic [7:0] EV_SWINC  = 8'h00;
  localparam logic [7:0] EV_CYCLE  = 8'h11;
  localparam logic [7:0] EV_EXT0   = 8'h90;
  localparam logic [7:0] EV_EXT1   = 8'h91;
  localparam logic [7:0] EV_EXTANY = 8'h92;
endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel #(
  parameter int EVW = 8
) (
  input  logic [EVW-1:0]        code,
  input  logic [(1<<EVW)-1:0]   core_evt,
  input  logic [1:0]            ext_evt,
  input  logic                  sw_pulse,
  output logic                  hit
);
  import pmu_pkg::*;

  always_comb begin
    case (code)
      EVW'(EV_SWINC):  hit = sw_pulse;
      EVW'(EV_CYCLE):  hit = 1'b1;
      EVW'(EV_EXT0):   hit = ext_evt[0];
      EVW'(EV_EXT1):   hit = ext_evt[1];
      EVW'(EV_EXTANY): hit = |ext_evt;
      default:         hit = core_evt[code];
    endcase
  end
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
  parameter int LOG = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic div_en,
  output logic tick
);
  logic [LOG-1:0] cnt_q;

  assign tick = run && !clr && (!div_en || (&cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end

  // R5: in divided mode two ticks are never adjacent
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && tick) |=> !tick);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);
  assign wrap = inc && !clr && !ld && (&q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (ld)   q <= ld_val;
    else if (inc)  q <= q + 1'b1;
  end

  // R10: a value write wins over a same-edge increment
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> q == $past(ld_val));
  // R2: with no increment, no load and no clear the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr && !ld) |=> $stable(q));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int NUM_EV = 6,
  parameter int CW     = 32,
  parameter int EVW    = 8,
  parameter int PS_LOG = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [3:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [(1<<EVW)-1:0]   core_evt,
  input  logic [1:0]            ext_evt,
  output logic                  irq
);
  import pmu_pkg::*;

  localparam int CYC_BIT = 31;
  localparam int SEL_W   = $clog2(NUM_EV + 1);
  localparam logic [31:0] IMPL_MASK = (32'h1 << CYC_BIT) | ((32'h1 << NUM_EV) - 32'h1);

  logic              run_q, div_q;
  logic [31:0]       en_q, irqen_q, ovf_q;
  logic [SEL_W-1:0]  sel_q;
  logic [EVW-1:0]    evtype_q [NUM_EV];
  logic [CW-1:0]     ev_cnt [NUM_EV];
  logic [NUM_EV-1:0] ev_wrap;
  logic [CW-1:0]     cyc_cnt;
  logic              cyc_wrap, cyc_tick;
  logic              sel_ok;
  logic [31:0]       wrap_vec;

  logic wr_ctrl, ev_rst, cy_rst;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign ev_rst  = wr_ctrl && reg_wdata[CTRL_EVRST];
  assign cy_rst  = wr_ctrl && reg_wdata[CTRL_CYRST];
  assign sel_ok  = (sel_q < SEL_W'(NUM_EV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      div_q   <= 1'b0;
      en_q    <= '0;
      irqen_q <= '0;
      sel_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          run_q <= reg_wdata[CTRL_RUN];
          div_q <= reg_wdata[CTRL_DIV];
        end
        A_ENSET:  en_q    <= en_q | (reg_wdata & IMPL_MASK);
        A_ENCLR:  en_q    <= en_q & ~reg_wdata;
        A_IRQSET: irqen_q <= irqen_q | (reg_wdata & IMPL_MASK);
        A_IRQCLR: irqen_q <= irqen_q & ~reg_wdata;
        A_SEL:    sel_q   <= reg_wdata[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  // overflow flags: a new wrap takes priority over a same-edge clear
  always_comb begin
    wrap_vec = '0;
    wrap_vec[NUM_EV-1:0] = ev_wrap;
    wrap_vec[CYC_BIT]    = cyc_wrap;
  end

  logic ovf_wr;
  assign ovf_wr = reg_wr && (reg_addr == A_OVF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= (ovf_q & ~(ovf_wr ? reg_wdata : 32'h0)) | wrap_vec;
  end

  assign irq = |(ovf_q & irqen_q);

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    logic hit, sw, ld, inc, mine;
    assign mine = (sel_q == SEL_W'(i));
    assign sw   = reg_wr && (reg_addr == A_SWINC) && reg_wdata[i];
    assign ld   = reg_wr && (reg_addr == A_EVVAL) && mine;
    assign inc  = run_q && en_q[i] && hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    evtype_q[i] <= '0;
      else if (reg_wr && reg_addr == A_EVTYPE && mine) evtype_q[i] <= reg_wdata[EVW-1:0];
    end

    pmu_event_sel #(.EVW(EVW)) u_sel (
      .code(evtype_q[i]), .core_evt(core_evt), .ext_evt(ext_evt),
      .sw_pulse(sw), .hit(hit)
    );

    pmu_counter #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(ev_rst), .ld(ld), .ld_val(reg_wdata[CW-1:0]),
      .inc(inc), .q(ev_cnt[i]), .wrap(ev_wrap[i])
    );
  end

  pmu_prescale #(.LOG(PS_LOG)) u_ps (
    .clk(clk), .rst_n(rst_n), .clr(cy_rst), .run(run_q && en_q[CYC_BIT]),
    .div_en(div_q), .tick(cyc_tick)
  );

  pmu_counter #(.W(CW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(cy_rst),
    .ld(reg_wr && reg_addr == A_CYCVAL), .ld_val(reg_wdata[CW-1:0]),
    .inc(cyc_tick), .q(cyc_cnt), .wrap(cyc_wrap)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTRL_RUN] = run_q;
        reg_rdata[CTRL_DIV] = div_q;
      end
      A_ENSET, A_ENCLR:   reg_rdata = en_q;
      A_IRQSET, A_IRQCLR: reg_rdata = irqen_q;
      A_OVF:              reg_rdata = ovf_q;
      A_SEL:              reg_rdata[SEL_W-1:0] = sel_q;
      A_EVTYPE: if (sel_ok) reg_rdata[EVW-1:0] = evtype_q[sel_q[SEL_W-1:0]];
      A_EVVAL:  if (sel_ok) reg_rdata[CW-1:0]  = ev_cnt[sel_q[SEL_W-1:0]];
      A_CYCVAL:           reg_rdata[CW-1:0] = cyc_cnt;
      default: ;
    endcase
  end

  // R8: a flag stays set unless software writes to the flag register
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_wr |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
  // R9: with no flag pending the interrupt is low
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q == 32'h0) |-> !irq);
  // R4: the self-clearing reset bits never read back as 1
  a_r4_rst_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> (reg_rdata[CTRL_CYRST:CTRL_EVRST] == 2'b00));
  // R3: unimplemented mask bits stay 0
  a_r3_mask_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & ~IMPL_MASK) == 32'h0) && ((irqen_q & ~IMPL_MASK) == 32'h0));
endmodule

// File: tb/perf_mon_unit_test.sv
module perf_mon_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [3:0]   reg_addr = 4'd0;
  logic [31:0]  reg_wdata = 32'd0;
  logic [31:0]  reg_rdata;
  logic [255:0] core_evt = '0;
  logic [1:0]   ext_evt = 2'b00;
  logic         irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  bit          kind_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  perf_mon_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_evt(core_evt),
    .ext_evt(ext_evt), .irq(irq)
  );

  // monitor: compares each expected item a quarter period after it is queued
  initial begin
    forever begin
      logic [31:0] act, exp;
      string tag;
      bit kind;
      wait (exp_q.size() != 0);
      #5;
      exp = exp_q.pop_front();
      kind = kind_q.pop_front();
      tag = tag_q.pop_front();
      act = kind ? {31'd0, irq} : reg_rdata;
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    exp_q.push_back({31'd0, e}); kind_q.push_back(1'b1); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, 32'h0, "R1 ctrl");
    rd(4'd1, 32'h0, "R1 enable mask");
    rd(4'd5, 32'h0, "R1 flags");
    rd(4'd10, 32'h0, "R1 cycle count");
    rd(4'd9, 32'h0, "R1 counter0");
    chk_irq(1'b0, "R1 irq");

    // R3 set/clear
    wr(4'd1, 32'h8000_0003);
    rd(4'd1, 32'h8000_0003, "R3 set");
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd2, 32'h8000_003F, "R3 unimplemented bits");
    wr(4'd2, 32'h0000_0002);
    rd(4'd1, 32'h8000_003D, "R3 clear one bit");
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd1, 32'h0, "R3 clear all");

    // R6/R7 programming
    wr(4'd7, 0); wr(4'd8, 32'h11);
    wr(4'd7, 1); wr(4'd8, 32'h90);
    wr(4'd7, 2); wr(4'd8, 32'h92);
    wr(4'd7, 3); wr(4'd8, 32'h00);
    wr(4'd7, 4); wr(4'd8, 32'h05);
    wr(4'd7, 5); wr(4'd8, 32'h91);
    wr(4'd7, 2);
    rd(4'd8, 32'h92, "R6 type readback");
    wr(4'd7, 6);
    wr(4'd8, 32'h33);
    rd(4'd8, 32'h0, "R6 out-of-range type");

    // R2/R7 counting: event counters on, cycle counter off
    ext_evt = 2'b01;
    core_evt[5] = 1'b1;
    wr(4'd1, 32'h0000_003F);
    wr(4'd0, 32'h1);
    idle(9);
    wr(4'd0, 32'h0);
    idle(5); // R2: global run off, nothing moves
    wr(4'd7, 0); rd(4'd9, 32'd10, "R7 cycle code");
    wr(4'd7, 1); rd(4'd9, 32'd10, "R7 ext0 code");
    wr(4'd7, 2); rd(4'd9, 32'd10, "R7 either-ext code");
    wr(4'd7, 3); rd(4'd9, 32'd0,  "R7 sw code idle");
    wr(4'd7, 4); rd(4'd9, 32'd10, "R7 core event code");
    wr(4'd7, 5); rd(4'd9, 32'd0,  "R7 ext1 low");
    rd(4'd10, 32'd0, "R2 cycle counter not enabled");

    // R7 software increment
    wr(4'd2, 32'h0000_0037);
    wr(4'd0, 32'h1);
    wr(4'd6, 32'h0000_0009);
    wr(4'd6, 32'h0000_0008);
    wr(4'd0, 32'h0);
    wr(4'd7, 3); rd(4'd9, 32'd2, "R7 sw increments");
    wr(4'd7, 0); rd(4'd9, 32'd10, "R2 disabled counter kept");

    // R4 resets
    wr(4'd10, 32'h55);
    wr(4'd0, 32'h2);
    rd(4'd0, 32'h0, "R4 reset bits read 0");
    wr(4'd7, 3); rd(4'd9, 32'd0, "R4 event counters cleared");
    rd(4'd10, 32'h55, "R4 cycle counter kept");
    wr(4'd0, 32'h4);
    rd(4'd10, 32'h0, "R4 cycle counter cleared");
    wr(4'd0, 32'h8);
    rd(4'd0, 32'h8, "R4 divide bit stored");

    // R5 divide by 64: 128 enabled edges
    wr(4'd2, 32'h0000_0008);
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h9);
    idle(127);
    wr(4'd0, 32'h8);
    rd(4'd10, 32'd2, "R5 prescaled count");
    wr(4'd0, 32'h4);

    // R8/R9 event counter wrap
    wr(4'd2, 32'h8000_0000);
    wr(4'd1, 32'h0000_0001);
    wr(4'd7, 0);
    wr(4'd9, 32'hFFFF_FFFE);
    wr(4'd3, 32'h0000_0001);
    wr(4'd0, 32'h1);
    idle(1);
    wr(4'd0, 32'h0);
    rd(4'd9, 32'h0, "R8 wrapped to zero");
    rd(4'd5, 32'h1, "R8 flag set");
    chk_irq(1'b1, "R9 irq raised");
    wr(4'd4, 32'h1);
    chk_irq(1'b0, "R9 masked");
    rd(4'd5, 32'h1, "R8 flag sticky under mask");
    wr(4'd3, 32'h1);
    chk_irq(1'b1, "R9 unmasked");
    wr(4'd5, 32'h1);
    rd(4'd5, 32'h0, "R8 write-one clear");
    chk_irq(1'b0, "R9 irq after clear");

    // R8 cycle counter wrap at bit 31
    wr(4'd10, 32'hFFFF_FFFF);
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h1);
    wr(4'd0, 32'h0);
    rd(4'd5, 32'h8000_0000, "R8 cycle flag bit31");
    chk_irq(1'b0, "R9 irq needs enable");
    wr(4'd5, 32'h8000_0000);
    rd(4'd5, 32'h0, "R8 cycle flag cleared");

    // R10 write wins over same-edge increment
    wr(4'd0, 32'h1);
    wr(4'd9, 32'h100);
    wr(4'd0, 32'h0);
    rd(4'd9, 32'h101, "R10 load priority");
    wr(4'd7, 6);
    wr(4'd9, 32'h5);
    rd(4'd9, 32'h0, "R6 out-of-range value");
    wr(4'd7, 0);
    rd(4'd9, 32'h101, "R6 counter0 untouched");

    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule